// File: doc/BRIEF.md
# Adaptive LMS Noise Canceller

This block removes correlated noise from a speech channel, one sample at a time. It takes two inputs. The primary channel carries speech mixed with noise. The reference channel carries noise only. A transversal FIR filter works over the recent reference history and forms an estimate of the noise present in the primary sample. That estimate is subtracted from the primary sample, and the difference is both the cleaned output and the error that drives adaptation.

A single multiplier and accumulator are shared in time. For each accepted sample the block first walks every tap to build the estimate. It then produces the output. Finally it walks every tap a second time to apply a least-mean-squares correction to each weight. An external decision input sets the sign of that correction. A shift amount sets its size as a power of two, and a freeze input suspends adaptation while filtering carries on. The surrounding system supplies one strobe per sample period and reads the result when the valid pulse appears.

Top module: `noise_canceller`

## Requirements
- R1: A high `in_strobe` seen at a clock edge while the block is idle accepts a sample. The 12-bit signed `ref_in` becomes history entry 0, and every older entry moves one place deeper (entry i holds x(n-i)). `prim_in`, `adapt_up`, `freeze` and `mu_shift` are captured at the same edge.
- R2: The noise estimate is acc = sum over i of w_i·x(n-i), using signed 16-bit weights with 14 fractional bits. The estimate is then acc arithmetically shifted right by 14.
- R3: `dout` = primary sample minus estimate, saturated to the range [-2048, 2047]. This same value is the error used for adaptation.
- R4: `out_valid` pulses high for exactly one cycle, TAPS+1 clock edges after the accepting edge. `dout` changes only at that edge and holds its value between pulses.
- R5: After the output, each weight receives delta_i = (e·x(n-i)) arithmetically shifted right by `mu_shift`. With `adapt_up`=1 the weight becomes w_i+delta_i; with `adapt_up`=0 it becomes w_i-delta_i. The result is saturated to [-32768, 32767].
- R6: A sample accepted with `freeze`=1 leaves every weight unchanged, but still produces its output as in R3 and R4.
- R7: A strobe is accepted again no earlier than TAPS+1 edges after the `out_valid` edge. A strobe arriving before that is ignored: it leaves the history untouched and produces no output.
- R8: A synchronous active-low reset clears all weights, the history, `dout` and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_strobe | input | 1 | New sample available on both channels |
| prim_in | input | 12 | Primary channel sample (speech plus noise), signed |
| ref_in | input | 12 | Reference channel sample (noise only), signed |
| adapt_up | input | 1 | Correction sign: 1 adds delta, 0 subtracts it |
| freeze | input | 1 | Suspends weight adaptation for this sample |
| mu_shift | input | 5 | Step size as a right-shift amount |
| dout | output | 12 | Cleaned output / adaptation error, signed |
| out_valid | output | 1 | One-cycle pulse when `dout` is new |

## Verification
The bench builds the block with 8 taps and the default widths. This lets the history turn over completely within a few samples, and a strobe can be aimed at the exact last busy edge and at the first idle edge. Small shift amounts paired with full-scale samples drive the weights into saturation within a handful of samples, which then pushes the output against both clamp limits. A bench-side model of the arithmetic supplies every expected output. Freeze and reset are also checked against values known in closed form.

// File: rtl/anc_pkg.sv
// Shared types for the adaptive noise canceller.
package anc_pkg;
    // Sequencer phases: wait, filter walk, error, weight walk.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_ERR  = 2'd2,
        ST_UPD  = 2'd3
    } anc_state_e;
endpackage

// File: rtl/anc_ctrl.sv
// Sequencer: accepts a sample when idle, walks the taps for filtering,
// spends one cycle on the error, then walks the taps again for the update.
// Assumes TAPS >= 2.
module anc_ctrl
    import anc_pkg::*;
#(
    parameter int TAPS  = 120,
    parameter int IDX_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_strobe,
    output logic             accept,
    output anc_state_e       state,
    output logic [IDX_W-1:0] idx
);
    logic last_tap;

    assign accept   = in_strobe && (state == ST_IDLE);
    assign last_tap = (idx == IDX_W'(TAPS - 1));

    // Phase and tap-index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (accept) state <= ST_MAC;
                end
                ST_MAC: begin
                    if (last_tap) begin
                        state <= ST_ERR;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_ERR: begin
                    state <= ST_UPD;
                    idx   <= '0;
                end
                default: begin
                    if (last_tap) begin
                        state <= ST_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/anc_history.sv
// Reference delay line: entry 0 is the newest sample, entry i is x(n-i).
// Shifts only when a sample is accepted; one random read port.
module anc_history #(
    parameter int DATA_W = 12,
    parameter int TAPS   = 120,
    parameter int IDX_W  = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    input  logic        [IDX_W-1:0]  rd_idx,
    output logic signed [DATA_W-1:0] rd_data,
    output logic signed [DATA_W-1:0] newest
);
    logic signed [DATA_W-1:0] hist_q [TAPS];

    genvar g;
    generate
        for (g = 0; g < TAPS; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Head stage loads the incoming reference sample.
                always_ff @(posedge clk) begin
                    if (!rst_n)        hist_q[g] <= '0;
                    else if (shift_en) hist_q[g] <= din;
                end
            end else begin : g_body
                // Deeper stages take the previous stage's sample.
                always_ff @(posedge clk) begin
                    if (!rst_n)        hist_q[g] <= '0;
                    else if (shift_en) hist_q[g] <= hist_q[g-1];
                end
            end
        end
    endgenerate

    assign rd_data = hist_q[rd_idx];
    assign newest  = hist_q[0];
endmodule

// File: rtl/anc_mac.sv
// Shared signed multiplier with a clearable accumulator.
// The product is used both for filtering (accumulated) and for the update.
module anc_mac #(
    parameter int A_W   = 16,
    parameter int B_W   = 12,
    parameter int ACC_W = 32,
    parameter int P_W   = A_W + B_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    acc_en,
    input  logic signed [A_W-1:0]   op_a,
    input  logic signed [B_W-1:0]   op_b,
    output logic signed [P_W-1:0]   prod,
    output logic signed [ACC_W-1:0] acc
);
    assign prod = op_a * op_b;

    // Accumulate one tap product per filtering cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (acc_en)   acc <= acc + ACC_W'(prod);
    end
endmodule

// File: rtl/anc_weights.sv
// Weight store with a saturating LMS update at the addressed tap.
// delta = prod >>> mu; the weight moves by +delta or -delta by the sign input.
module anc_weights #(
    parameter int COEF_W = 16,
    parameter int TAPS   = 120,
    parameter int IDX_W  = $clog2(TAPS),
    parameter int P_W    = 28,
    parameter int MU_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic        [IDX_W-1:0]  idx,
    output logic signed [COEF_W-1:0] rd_w,
    input  logic                     upd_en,
    input  logic                     hold,
    input  logic                     up,
    input  logic        [MU_W-1:0]   mu,
    input  logic signed [P_W-1:0]    prod
);
    localparam int SUM_W = P_W + 2;
    localparam logic signed [SUM_W-1:0] W_MAX = SUM_W'((1 <<< (COEF_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] W_MIN = SUM_W'(-(1 <<< (COEF_W - 1)));

    logic signed [COEF_W-1:0] w_q [TAPS];
    logic signed [P_W-1:0]    delta;
    logic signed [SUM_W-1:0]  sum;
    logic signed [COEF_W-1:0] nxt_w;

    assign rd_w  = w_q[idx];
    assign delta = prod >>> mu;

    // Signed step and clamp to the weight range.
    always_comb begin
        sum = up ? (SUM_W'(rd_w) + SUM_W'(delta)) : (SUM_W'(rd_w) - SUM_W'(delta));
        if (sum > W_MAX)      nxt_w = W_MAX[COEF_W-1:0];
        else if (sum < W_MIN) nxt_w = W_MIN[COEF_W-1:0];
        else                  nxt_w = sum[COEF_W-1:0];
    end

    // Clear on reset, write the addressed weight during an unfrozen update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) w_q[i] <= '0;
        end else if (upd_en && !hold) begin
            w_q[idx] <= nxt_w;
        end
    end

    AST_STEP_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && up && delta >= 0) |-> (nxt_w >= rd_w)); // R5
    AST_STEP_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !up && delta >= 0) |-> (nxt_w <= rd_w)); // R5
endmodule

// File: rtl/noise_canceller.sv
// Adaptive LMS noise canceller. Per accepted sample: TAPS filter cycles,
// one error cycle (output pulse), TAPS update cycles. Expects the next strobe
// no sooner than 2*TAPS+2 edges after the previous accepting edge; earlier
// strobes are dropped.
module noise_canceller
    import anc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int TAPS   = 120,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 14,
    parameter int ACC_W  = 32,
    parameter int MU_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_strobe,
    input  logic signed [DATA_W-1:0] prim_in,
    input  logic signed [DATA_W-1:0] ref_in,
    input  logic                     adapt_up,
    input  logic                     freeze,
    input  logic        [MU_W-1:0]   mu_shift,
    output logic signed [DATA_W-1:0] dout,
    output logic                     out_valid
);
    localparam int IDX_W  = $clog2(TAPS);
    localparam int P_W    = COEF_W + DATA_W;
    localparam int DIFF_W = ACC_W + 1;
    localparam logic signed [DIFF_W-1:0] D_MAX = DIFF_W'((1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] D_MIN = DIFF_W'(-(1 <<< (DATA_W - 1)));

    anc_state_e               state;
    logic                     accept;
    logic [IDX_W-1:0]         idx;
    logic signed [DATA_W-1:0] x_rd, x_newest;
    logic signed [COEF_W-1:0] w_rd, op_a;
    logic signed [P_W-1:0]    prod;
    logic signed [ACC_W-1:0]  acc, est;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DATA_W-1:0] err_sat, d_q;
    logic                     up_q, frz_q;
    logic [MU_W-1:0]          mu_q;

    anc_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe),
        .accept(accept), .state(state), .idx(idx)
    );

    anc_history #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(ref_in),
        .rd_idx(idx), .rd_data(x_rd), .newest(x_newest)
    );

    // Multiplier operand: weight when filtering, error when updating.
    assign op_a = (state == ST_UPD) ? COEF_W'(dout) : w_rd;

    anc_mac #(.A_W(COEF_W), .B_W(DATA_W), .ACC_W(ACC_W), .P_W(P_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(accept), .acc_en(state == ST_MAC),
        .op_a(op_a), .op_b(x_rd), .prod(prod), .acc(acc)
    );

    anc_weights #(.COEF_W(COEF_W), .TAPS(TAPS), .IDX_W(IDX_W), .P_W(P_W),
                  .MU_W(MU_W)) u_wts (
        .clk(clk), .rst_n(rst_n), .idx(idx), .rd_w(w_rd),
        .upd_en(state == ST_UPD), .hold(frz_q), .up(up_q), .mu(mu_q),
        .prod(prod)
    );

    // Capture primary sample and adaptation controls with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q   <= '0;
            up_q  <= 1'b0;
            frz_q <= 1'b0;
            mu_q  <= '0;
        end else if (accept) begin
            d_q   <= prim_in;
            up_q  <= adapt_up;
            frz_q <= freeze;
            mu_q  <= mu_shift;
        end
    end

    // Error = primary minus scaled estimate, clamped to the sample range.
    assign est  = acc >>> FRAC_W;
    assign diff = DIFF_W'(d_q) - DIFF_W'(est);
    always_comb begin
        if (diff > D_MAX)      err_sat = D_MAX[DATA_W-1:0];
        else if (diff < D_MIN) err_sat = D_MIN[DATA_W-1:0];
        else                   err_sat = diff[DATA_W-1:0];
    end

    // Output register and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= (state == ST_ERR);
            if (state == ST_ERR) dout <= err_sat;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(dout)); // R4
    AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(x_newest)); // R7
endmodule

// File: tb/tb_noise_canceller.sv
// Bench: stimulus table walked by one loop against an arithmetic model,
// then directed tests for reset, freeze and the busy window.
module tb_noise_canceller;
    localparam int DW = 12, TAPS = 8, CW = 16, FRAC = 14, AW = 32, MW = 5;

    typedef struct packed {
        logic signed [DW-1:0] d;
        logic signed [DW-1:0] x;
        logic                 up;
        logic                 frz;
        logic [MW-1:0]        mu;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{ 12'sd100,   12'sd200,   1'b1, 1'b0, 5'd6 },
        '{ -12'sd300,  12'sd400,   1'b1, 1'b0, 5'd6 },
        '{ 12'sd500,   -12'sd250,  1'b1, 1'b0, 5'd5 },
        '{ 12'sd0,     12'sd1000,  1'b1, 1'b0, 5'd4 },
        '{ 12'sd1500,  12'sd1500,  1'b1, 1'b0, 5'd2 },
        '{ -12'sd2000, -12'sd1800, 1'b1, 1'b0, 5'd0 },
        '{ 12'sd2047,  12'sd2047,  1'b0, 1'b0, 5'd3 },
        '{ -12'sd2048, 12'sd2047,  1'b0, 1'b0, 5'd3 },
        '{ 12'sd700,   -12'sd900,  1'b1, 1'b1, 5'd1 },
        '{ 12'sd700,   -12'sd900,  1'b1, 1'b1, 5'd1 },
        '{ -12'sd50,   12'sd60,    1'b0, 1'b0, 5'd8 },
        '{ 12'sd1234,  -12'sd1234, 1'b1, 1'b0, 5'd10 }
    };

    logic clk = 1'b0, rst_n = 1'b0, in_strobe = 1'b0;
    logic adapt_up = 1'b0, freeze = 1'b0;
    logic signed [DW-1:0] prim_in = '0, ref_in = '0;
    logic [MW-1:0] mu_shift = '0;
    logic signed [DW-1:0] dout;
    logic out_valid;

    always #2 clk = ~clk;

    noise_canceller #(.DATA_W(DW), .TAPS(TAPS), .COEF_W(CW), .FRAC_W(FRAC),
                      .ACC_W(AW), .MU_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .prim_in(prim_in),
        .ref_in(ref_in), .adapt_up(adapt_up), .freeze(freeze),
        .mu_shift(mu_shift), .dout(dout), .out_valid(out_valid)
    );

    int checks = 0, fails = 0;
    longint m_w [TAPS];
    longint m_h [TAPS];

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clamp(longint v, longint lo, longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < TAPS; i++) begin
            m_w[i] = 0;
            m_h[i] = 0;
        end
    endfunction

    // Arithmetic from R1, R2, R3, R5, R6.
    function automatic longint model(longint d, longint x, bit up, bit frz, int mu);
        longint acc, e, delta;
        for (int i = TAPS - 1; i > 0; i--) m_h[i] = m_h[i-1];
        m_h[0] = x;
        acc = 0;
        for (int i = 0; i < TAPS; i++) acc += m_w[i] * m_h[i];
        e = clamp(d - (acc >>> FRAC), -2048, 2047);
        if (!frz) begin
            for (int i = 0; i < TAPS; i++) begin
                delta = (e * m_h[i]) >>> mu;
                m_w[i] = clamp(up ? m_w[i] + delta : m_w[i] - delta, -32768, 32767);
            end
        end
        return e;
    endfunction

    // Drive one sample at a negedge, wait for the pulse, check latency,
    // value and pulse width. Returns at the negedge after the pulse edge +1.
    task automatic send(longint d, longint x, bit up, bit frz, int mu, string req);
        longint exp;
        int n;
        exp = model(d, x, up, frz, mu);
        prim_in = DW'(d); ref_in = DW'(x); adapt_up = up; freeze = frz;
        mu_shift = MW'(mu); in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
        n = 0;
        while (!out_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R4 latency", n, TAPS + 1);
        check(req, dout, exp);
        @(negedge clk);
        check("R4 pulse width", out_valid, 0);
    endtask

    // Remaining busy edges before the first edge that may accept a strobe.
    task automatic gap();
        repeat (TAPS - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        check("R8 reset dout", dout, 0);
        check("R8 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int seen;
        logic signed [DW-1:0] held;
        model_clear();
        do_reset();

        // Table walk: R1 history order, R2 estimate, R3 clamp, R5 step, R6 freeze.
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].d, VEC[i].x, VEC[i].up, VEC[i].frz, int'(VEC[i].mu),
                 VEC[i].frz ? "R6 frozen output" : "R1/R2/R3/R5 output");
            gap();
        end

        // R7: strobe at the last busy edge is ignored.
        send(300, -400, 1'b1, 1'b0, 4, "R2/R3 pre-ignore output");
        repeat (TAPS - 2) @(negedge clk);
        held = dout;
        prim_in = -12'sd999; ref_in = 12'sd1777; in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
        seen = 0;
        repeat (TAPS + 4) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check("R7 no pulse from busy strobe", seen, 0);
        check("R7 dout unchanged by busy strobe", dout, held);
        send(-120, 220, 1'b0, 1'b0, 5, "R7 history untouched by busy strobe");
        gap();

        // R8 mid-run reset, then R6 freeze with zero weights: output equals primary.
        do_reset();
        send(500, 300, 1'b1, 1'b1, 0, "R6 frozen zero weights");
        gap();
        send(-700, 2000, 1'b1, 1'b1, 0, "R6 frozen zero weights");
        gap();
        check("R6 closed form", dout, -700);
        send(400, 1500, 1'b1, 1'b0, 6, "R8 first adapt after reset");
        check("R8 zero weights give primary", dout, 400);
        gap();
        send(400, 1500, 1'b1, 1'b0, 6, "R5 adapted output");
        gap();

        // R3 clamp at both limits with saturated weights.
        send(2047, 2047, 1'b1, 1'b0, 0, "R3 upper region");
        gap();
        send(-2048, -2047, 1'b1, 1'b0, 0, "R3 lower region");
        gap();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule